// File: doc/BRIEF.md
# Sleep Wake-Up Control Registers

This block is the register slice of a power manager that decides which events may wake the system and which clock speed code the core clock generator uses. It holds a wake-enable register and a 5-bit clock configuration register. Both are reached over a simple memory-mapped bus: a one-cycle write strobe with an address and data, and a read data port driven combinationally from the address.

While the sleep-mode input is high, the block combines the enable bits with per-GPIO edge pulses, GPIO direction bits and an RTC alarm into one wake-up request. A supply or battery fault puts the enable register back to a safe value that allows only GPIO 0 and GPIO 1 to wake the system. The clock code keeps its value through sleep and faults and is driven out continuously. The asynchronous active-low hard reset is released through a two-stage synchronizer, so the registers leave reset on the second rising clock edge after `rst_n` goes high.

Top module: `wake_ctrl_regs`

## Requirements
- R1: After hard reset, the wake-enable register reads 0x00000003, and the clock code reads 0 and drives 0 on `clk_code`.
- R2: A write at byte offset 0x0C stores bits 27..0 (GPIO n enable at bit n) and bit 31 (RTC enable) of the wake-enable register, and a read at 0x0C returns them.
- R3: Bits 30..28 of the wake-enable register always read 0, and writing ones to them has no effect.
- R4: When `supply_fault` or `battery_fault` is high at a rising edge, the wake-enable register holds 0x00000003 after that edge, even if a bus write to 0x0C happens in the same cycle.
- R5: A write at byte offset 0x14 stores `bus_wdata[4:0]` as the clock code. A read at 0x14 returns the code in bits 4..0 with zeros above it, and `clk_code` shows the stored code from the cycle after the write.
- R6: The clock code is unchanged by faults, by sleep entry and exit, and by writes to other offsets. Only hard reset clears it.
- R7: With `sleep_active` high, `wake_req` is high when, for some GPIO n in 0..27, `gpio_edge[n]`, enable bit n and `gpio_is_input[n]` (1 means input) are all high. An edge on a GPIO configured as an output never wakes the system.
- R8: With `sleep_active` high, `wake_req` is high when `rtc_alarm` and enable bit 31 are both high.
- R9: `wake_req` is low whenever `sleep_active` is low.
- R10: Reads at any offset other than 0x0C and 0x14 return 0, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_addr | input | 8 | Byte offset within the power-manager space |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| supply_fault | input | 1 | Supply fault indication |
| battery_fault | input | 1 | Battery fault indication |
| sleep_active | input | 1 | High while the system sleeps |
| gpio_edge | input | 28 | Edge-detect pulse per GPIO |
| gpio_is_input | input | 28 | GPIO direction, 1 = input |
| rtc_alarm | input | 1 | RTC alarm event |
| wake_req | output | 1 | Wake-up request to the sleep sequencer |
| clk_code | output | 5 | Clock speed code for the clock generator |

## Verification
The wake combination is driven with single-GPIO patterns in which exactly one of the three terms (edge pulse, enable bit, input direction) is missing. This shows that each term is required. The lowest and highest GPIO indices are tried to catch wrong bit slicing, and an all-edges pattern with only GPIO 0 both enabled and an input shows that one qualified source is enough. RTC patterns pair the alarm with bit 31 and with only the GPIO enables, which separates the RTC path from the GPIO paths. Every pattern that would otherwise wake the system is repeated with sleep low to show the sleep gate. Directed sequences then place a fault on the same edge as an all-ones write, change sleep and fault around a stored clock code, and write to unmapped offsets. These sequences show the override priority and that the clock code is kept.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WAKE = 2'd1,
    SEL_CLK  = 2'd2
  } reg_sel_e;

  // Implemented bits of the wake-enable register: GPIO enables and the RTC bit.
  function automatic logic [REG_W-1:0] wake_mask(input int ngpio, input int rtc_bit);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < ngpio || i == rtc_bit) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/wake_rst_sync.sv
module wake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wake_en_reg.sv
module wake_en_reg
  import wake_pkg::*;
#(
  parameter int              NUM_GPIO  = 28,
  parameter int              RTC_BIT   = 31,
  parameter logic [REG_W-1:0] SAFE_VAL = 32'h0000_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             fault,
  output logic [REG_W-1:0] en_q
);

  localparam logic [REG_W-1:0] MASK = wake_mask(NUM_GPIO, RTC_BIT);

  logic             load;
  logic [REG_W-1:0] en_d;

  // A fault wins over a write in the same cycle.
  always_comb begin
    load = fault | wr_en;
    if (fault) en_d = SAFE_VAL & MASK;
    else       en_d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= SAFE_VAL & MASK;
    else if (load) en_q <= en_d;
  end

endmodule

// File: rtl/clk_cfg_reg.sv
module clk_cfg_reg #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wcode,
  output logic [CODE_W-1:0] code_q
);

  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = wcode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (wr_en) code_q <= code_d;
  end

endmodule

// File: rtl/wake_combine.sv
module wake_combine
  import wake_pkg::*;
#(
  parameter int NUM_GPIO = 28,
  parameter int RTC_BIT  = 31
) (
  input  logic                sleep_active,
  input  logic [NUM_GPIO-1:0] gpio_edge,
  input  logic [NUM_GPIO-1:0] gpio_is_input,
  input  logic                rtc_alarm,
  input  logic [REG_W-1:0]    en_q,
  output logic                wake_req
);

  logic [NUM_GPIO-1:0] gpio_hit;
  logic                rtc_hit;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_src
    assign gpio_hit[g] = gpio_edge[g] & en_q[g] & gpio_is_input[g];
  end

  assign rtc_hit  = rtc_alarm & en_q[RTC_BIT];
  assign wake_req = sleep_active & ((|gpio_hit) | rtc_hit);

endmodule

// File: rtl/wake_ctrl_regs.sv
module wake_ctrl_regs
  import wake_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                NUM_GPIO    = 28,
  parameter int                CODE_W      = 5,
  parameter int                RTC_BIT     = 31,
  parameter logic [ADDR_W-1:0] WAKE_OFFSET = 8'h0C,
  parameter logic [ADDR_W-1:0] CLK_OFFSET  = 8'h14,
  parameter logic [31:0]       SAFE_VAL    = 32'h0000_0003
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                supply_fault,
  input  logic                battery_fault,
  input  logic                sleep_active,
  input  logic [NUM_GPIO-1:0] gpio_edge,
  input  logic [NUM_GPIO-1:0] gpio_is_input,
  input  logic                rtc_alarm,
  output logic                wake_req,
  output logic [CODE_W-1:0]   clk_code
);

  localparam int PAD_W = REG_W - CODE_W;

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             wake_wr;
  logic             clk_wr;
  logic [REG_W-1:0] en_q;
  logic             fault;

  wake_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    if (bus_addr == WAKE_OFFSET)     sel = SEL_WAKE;
    else if (bus_addr == CLK_OFFSET) sel = SEL_CLK;
    else                             sel = SEL_NONE;
    wake_wr = bus_wr && (sel == SEL_WAKE);
    clk_wr  = bus_wr && (sel == SEL_CLK);
    fault   = supply_fault | battery_fault;
  end

  wake_en_reg #(
    .NUM_GPIO (NUM_GPIO),
    .RTC_BIT  (RTC_BIT),
    .SAFE_VAL (SAFE_VAL)
  ) u_en (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wake_wr),
    .wdata (bus_wdata),
    .fault (fault),
    .en_q  (en_q)
  );

  clk_cfg_reg #(.CODE_W(CODE_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (clk_wr),
    .wcode  (bus_wdata[CODE_W-1:0]),
    .code_q (clk_code)
  );

  wake_combine #(
    .NUM_GPIO (NUM_GPIO),
    .RTC_BIT  (RTC_BIT)
  ) u_comb (
    .sleep_active  (sleep_active),
    .gpio_edge     (gpio_edge),
    .gpio_is_input (gpio_is_input),
    .rtc_alarm     (rtc_alarm),
    .en_q          (en_q),
    .wake_req      (wake_req)
  );

  always_comb begin
    case (sel)
      SEL_WAKE: bus_rdata = en_q;
      SEL_CLK:  bus_rdata = {{PAD_W{1'b0}}, clk_code};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk #(
  parameter int          ADDR_W      = 8,
  parameter int          NUM_GPIO    = 28,
  parameter int          CODE_W      = 5,
  parameter logic [7:0]  WAKE_OFFSET = 8'h0C,
  parameter logic [7:0]  CLK_OFFSET  = 8'h14
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic                supply_fault,
  input logic                battery_fault,
  input logic                sleep_active,
  input logic [NUM_GPIO-1:0] gpio_edge,
  input logic [NUM_GPIO-1:0] gpio_is_input,
  input logic                rtc_alarm,
  input logic                wake_req,
  input logic [CODE_W-1:0]   clk_code,
  input logic [31:0]         en_q
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == WAKE_OFFSET) |-> (bus_rdata[30:28] == 3'b000)); // R3

  AST_FAULT_FORCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_fault || battery_fault) |=> (en_q == 32'h0000_0003)); // R4

  AST_CLK_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == CLK_OFFSET) |=> (clk_code == $past(bus_wdata[CODE_W-1:0]))); // R5

  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && bus_addr == CLK_OFFSET) |=> $stable(clk_code)); // R6

  AST_GPIO0_WAKE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep_active && gpio_edge[0] && gpio_is_input[0] && en_q[0]) |-> wake_req); // R7

  AST_RTC_WAKE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep_active && rtc_alarm && en_q[31]) |-> wake_req); // R8

  AST_AWAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sleep_active |-> !wake_req); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr != WAKE_OFFSET && bus_addr != CLK_OFFSET) |-> (bus_rdata == 32'h0)); // R10

endmodule

bind wake_ctrl_regs wake_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_GPIO (NUM_GPIO),
  .CODE_W   (CODE_W)
) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .supply_fault  (supply_fault),
  .battery_fault (battery_fault),
  .sleep_active  (sleep_active),
  .gpio_edge     (gpio_edge),
  .gpio_is_input (gpio_is_input),
  .rtc_alarm     (rtc_alarm),
  .wake_req      (wake_req),
  .clk_code      (clk_code),
  .en_q          (en_q)
);

// File: tb/tb_wake_ctrl_regs.sv
`timescale 1ns/1ps
module tb_wake_ctrl_regs;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        supply_fault;
  logic        battery_fault;
  logic        sleep_active;
  logic [27:0] gpio_edge;
  logic [27:0] gpio_is_input;
  logic        rtc_alarm;
  logic        wake_req;
  logic [4:0]  clk_code;

  int checks = 0;
  int fails  = 0;

  wake_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .supply_fault(supply_fault), .battery_fault(battery_fault),
    .sleep_active(sleep_active), .gpio_edge(gpio_edge),
    .gpio_is_input(gpio_is_input), .rtc_alarm(rtc_alarm),
    .wake_req(wake_req), .clk_code(clk_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        sleep;
    logic [27:0] edg;
    logic [27:0] dir;
    logic        rtc;
    logic [31:0] en;
    logic        exp;
  } vec_t;

  // Wake combination patterns: R7 GPIO qualification, R8 RTC path, R9 sleep gate.
  localparam vec_t VECS [10] = '{
    '{4'd7, 1'b1, 28'h0000020, 28'h0000020, 1'b0, 32'h0000_0020, 1'b1},
    '{4'd7, 1'b1, 28'h0000020, 28'h0000000, 1'b0, 32'h0000_0020, 1'b0},
    '{4'd7, 1'b1, 28'h0000020, 28'hFFFFFFF, 1'b0, 32'h0000_0010, 1'b0},
    '{4'd7, 1'b1, 28'h0000000, 28'hFFFFFFF, 1'b0, 32'h0FFF_FFFF, 1'b0},
    '{4'd7, 1'b1, 28'h8000000, 28'h8000000, 1'b0, 32'h0800_0000, 1'b1},
    '{4'd7, 1'b1, 28'hFFFFFFF, 28'h0000001, 1'b0, 32'h0000_0001, 1'b1},
    '{4'd8, 1'b1, 28'h0000000, 28'h0000000, 1'b1, 32'h8000_0000, 1'b1},
    '{4'd8, 1'b1, 28'h0000000, 28'hFFFFFFF, 1'b1, 32'h0FFF_FFFF, 1'b0},
    '{4'd9, 1'b0, 28'h0000020, 28'h0000020, 1'b0, 32'h0000_0020, 1'b0},
    '{4'd9, 1'b0, 28'h0000000, 28'h0000000, 1'b1, 32'h8000_0000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    supply_fault = 1'b0; battery_fault = 1'b0; sleep_active = 1'b0;
    gpio_edge = '0; gpio_is_input = '0; rtc_alarm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(8'h0C, rd); check("R1 enable after reset", rd, 32'h3);
    bus_read(8'h14, rd); check("R1 clock code read after reset", rd, 32'h0);
    check("R1 clk_code port after reset", {27'd0, clk_code}, 32'h0);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      bus_write(8'h0C, VECS[i].en);
      @(negedge clk);
      sleep_active  = VECS[i].sleep;
      gpio_edge     = VECS[i].edg;
      gpio_is_input = VECS[i].dir;
      rtc_alarm     = VECS[i].rtc;
      #1;
      check($sformatf("R%0d wake vector %0d", VECS[i].req, i), {31'd0, wake_req}, {31'd0, VECS[i].exp});
      @(negedge clk);
      sleep_active = 1'b0; gpio_edge = '0; gpio_is_input = '0; rtc_alarm = 1'b0;
    end

    // R2 store and read back the implemented bits
    bus_write(8'h0C, 32'h8ABC_DEF5);
    bus_read(8'h0C, rd); check("R2 enable readback", rd, 32'h8ABC_DEF5);
    // R3 reserved bits ignored
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h0C, rd); check("R3 reserved bits read zero", rd, 32'h8FFF_FFFF);

    // R5 clock code write, upper bits dropped, port follows
    bus_write(8'h14, 32'hFFFF_FFF6);
    bus_read(8'h14, rd); check("R5 clock code read", rd, 32'h16);
    check("R5 clk_code port", {27'd0, clk_code}, 32'h16);

    // R4 supply fault on the same edge as an all-ones write
    @(negedge clk);
    bus_addr = 8'h0C; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; supply_fault = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; supply_fault = 1'b0;
    bus_read(8'h0C, rd); check("R4 supply fault beats write", rd, 32'h3);
    // R4 battery fault
    bus_write(8'h0C, 32'h8000_00F0);
    @(negedge clk); battery_fault = 1'b1;
    @(negedge clk); battery_fault = 1'b0;
    bus_read(8'h0C, rd); check("R4 battery fault forces safe value", rd, 32'h3);

    // R6 clock code survives faults, sleep and writes elsewhere
    @(negedge clk); sleep_active = 1'b1; supply_fault = 1'b1;
    repeat (2) @(negedge clk); sleep_active = 1'b0; supply_fault = 1'b0;
    bus_write(8'h0C, 32'h0000_0100);
    bus_read(8'h14, rd); check("R6 clock code kept", rd, 32'h16);

    // R10 unmapped offsets
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h10, rd); check("R10 unmapped read zero", rd, 32'h0);
    bus_read(8'h0C, rd); check("R10 enable untouched", rd, 32'h0000_0100);
    bus_read(8'h14, rd); check("R10 clock code untouched", rd, 32'h16);

    // R6 and R1 hard reset clears the code and restores enable
    hard_reset();
    bus_read(8'h14, rd); check("R6 hard reset clears code", rd, 32'h0);
    bus_read(8'h0C, rd); check("R1 enable after second reset", rd, 32'h3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule